// File: doc/BRIEF.md
# Fuse-Programmable Sum-of-Products Logic Array

This block models a small programmable array logic device. Ten dedicated input pins and six pins read back from the output side form sixteen array variables. Every product term can connect to each variable in its true form, its complemented form, or both. The AND plane is programmable. The OR plane is fixed: each of the eight output pins owns seven sum terms that feed its OR gate, and the pin drives the complement of that OR. An eighth term on each output drives that pin's three-state enable, and outputs never share terms. An output pin whose enable is false can therefore act as one more input, through its read-back path.

The connection map holds 2048 fuse bits. It is loaded one bit per accepted cycle through a serial configuration port. A done flag rises once the whole map is in place. Until that flag rises, every pin stays disabled. Once the flag is set, the map is frozen until the next reset.

Top module: `pal_array`

## Requirements
- R1: After reset, cfgDone is 0 and every bit of ioOe is 0.
- R2: Each cycle with cfgValid high accepts one bit from cfgBit. cfgDone is still 0 after 2047 accepted bits and becomes 1 on the clock edge that accepts bit 2048.
- R3: While cfgDone is 0, ioOe stays all zero, whatever the inputs and the partly loaded map.
- R4: After cfgDone is 1, further cfgValid pulses have no effect. cfgDone stays 1 and the pin behaviour keeps following the map loaded first.
- R5: The k-th accepted bit (k counting from 0) is fuse k. Fuse k with k = (output*8 + term)*32 + column belongs to that output and term. Term 0 is the enable term and terms 1 to 7 are sum terms. Column 2v is variable v true and column 2v+1 is variable v complemented. Variables 0 to 9 are dedIn[0..9] and variables 10 to 15 are ioIn[0..5].
- R6: A fuse of 1 connects its literal to the term, and a term is the AND of its connected literals. A term with every fuse at 1 is always 0, and a term with every fuse at 0 is always 1.
- R7: ioOut[o] is the complement of the OR of output o's sum terms 1 to 7. Terms that belong to other outputs do not affect it.
- R8: Once cfgDone is 1, ioOe[o] equals output o's term 0.
- R9: Only ioIn[0..5] reach the array, and they act as ordinary variables 10 to 15.
- R10: A map loaded with every fuse at 1 leaves all pins disabled and drives every ioOut bit to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgValid | input | 1 | Configuration bit strobe |
| cfgBit | input | 1 | Serial fuse data, fuse 0 first |
| cfgDone | output | 1 | Map fully loaded |
| dedIn | input | 10 | Dedicated input pins |
| ioIn | input | 6 | Values read back from output pins 0 to 5 |
| ioOut | output | 8 | Active-low pin data |
| ioOe | output | 8 | Per-pin three-state enable |

## Verification
The bench uses the default parameters: ten dedicated inputs, eight outputs, six read-back pins and seven sum terms. With these values the whole 1024-value space of the dedicated inputs can be swept against one loaded map, and all 64 read-back patterns can be swept on top of a fixed input word. It loads two maps. The first is fully intact. The second mixes hashed literals with directed terms: always-true, always-false, single read-back literals and an input-driven enable. Each pin is checked against a model the bench evaluates directly from its own copy of the fuse image.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef struct packed {
    logic shiftEn;   // accept cfgBit into the fuse map this cycle
    logic armed;     // map complete, pins may be enabled
  } cfgStrobe_t;
endpackage

// File: rtl/pal_product_term.sv
module pal_product_term #(
  parameter int NUM_VARS = 16
) (
  input  logic [2*NUM_VARS-1:0] fuseRow,
  input  logic [NUM_VARS-1:0]   arrayVars,
  output logic                  termHit
);
  logic [2*NUM_VARS-1:0] literals;

  for (genvar v = 0; v < NUM_VARS; v++) begin : g_lit
    assign literals[2*v]   = arrayVars[v];
    assign literals[2*v+1] = ~arrayVars[v];
  end

  // A connected literal that is false kills the term; open columns pass.
  assign termHit = &(~fuseRow | literals);
endmodule

// File: rtl/pal_cfg_ctrl.sv
module pal_cfg_ctrl
  import pal_pkg::*;
#(
  parameter int FUSE_BITS = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgValid,
  output cfgStrobe_t strobe,
  output logic       cfgDone
);
  localparam int CW = $clog2(FUSE_BITS + 1);

  logic [CW-1:0] bitCount;
  logic          doneQ;
  logic          takeBit;

  assign takeBit = cfgValid & ~doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
      doneQ    <= 1'b0;
    end else if (takeBit) begin
      bitCount <= bitCount + CW'(1);
      if (bitCount == CW'(FUSE_BITS - 1)) doneQ <= 1'b1;
    end
  end

  assign strobe.shiftEn = takeBit;
  assign strobe.armed   = doneQ;
  assign cfgDone        = doneQ;

  assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> doneQ);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= CW'(FUSE_BITS));
  assert_done_at_full_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> (bitCount == CW'(FUSE_BITS)));
  assert_count_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> $stable(bitCount));
endmodule

// File: rtl/pal_fuse_array.sv
module pal_fuse_array
  import pal_pkg::*;
#(
  parameter int NUM_IN    = 10,
  parameter int NUM_OUT   = 8,
  parameter int NUM_FB    = 6,
  parameter int SUM_TERMS = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfgStrobe_t         strobe,
  input  logic               cfgBit,
  input  logic [NUM_IN-1:0]  dedIn,
  input  logic [NUM_FB-1:0]  ioIn,
  output logic [NUM_OUT-1:0] ioOut,
  output logic [NUM_OUT-1:0] ioOe
);
  localparam int NUM_VARS  = NUM_IN + NUM_FB;
  localparam int NCOLS     = 2 * NUM_VARS;
  localparam int TPO       = SUM_TERMS + 1;
  localparam int FUSE_BITS = NUM_OUT * TPO * NCOLS;

  logic [FUSE_BITS-1:0] fuseMap;
  logic [NUM_VARS-1:0]  arrayVars;

  // Unprogrammed state: every fuse intact.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               fuseMap <= '1;
    else if (strobe.shiftEn) fuseMap <= {cfgBit, fuseMap[FUSE_BITS-1:1]};
  end

  assign arrayVars = {ioIn, dedIn};

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [TPO-1:0] termHit;
    for (genvar t = 0; t < TPO; t++) begin : g_term
      pal_product_term #(.NUM_VARS(NUM_VARS)) term_i (
        .fuseRow  (fuseMap[((o*TPO)+t)*NCOLS +: NCOLS]),
        .arrayVars(arrayVars),
        .termHit  (termHit[t])
      );
    end
    assign ioOe[o]  = strobe.armed & termHit[0];
    assign ioOut[o] = ~(|termHit[TPO-1:1]);
  end

  assert_oe_off_unloaded_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.armed |-> (ioOe == '0));
  assert_map_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.shiftEn) |-> $stable(fuseMap));
endmodule

// File: rtl/pal_array.sv
module pal_array
  import pal_pkg::*;
#(
  parameter int NUM_IN    = 10,
  parameter int NUM_OUT   = 8,
  parameter int NUM_FB    = 6,
  parameter int SUM_TERMS = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgValid,
  input  logic               cfgBit,
  output logic               cfgDone,
  input  logic [NUM_IN-1:0]  dedIn,
  input  logic [NUM_FB-1:0]  ioIn,
  output logic [NUM_OUT-1:0] ioOut,
  output logic [NUM_OUT-1:0] ioOe
);
  localparam int FUSE_BITS = NUM_OUT * (SUM_TERMS + 1) * 2 * (NUM_IN + NUM_FB);

  cfgStrobe_t strobe;

  pal_cfg_ctrl #(.FUSE_BITS(FUSE_BITS)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cfgValid(cfgValid),
    .strobe  (strobe),
    .cfgDone (cfgDone)
  );

  pal_fuse_array #(
    .NUM_IN   (NUM_IN),
    .NUM_OUT  (NUM_OUT),
    .NUM_FB   (NUM_FB),
    .SUM_TERMS(SUM_TERMS)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .cfgBit(cfgBit),
    .dedIn (dedIn),
    .ioIn  (ioIn),
    .ioOut (ioOut),
    .ioOe  (ioOe)
  );
endmodule

// File: tb/pal_array_tb.sv
`timescale 1ns/1ps
module pal_array_tb_top;
  localparam int NI  = 10;
  localparam int NO  = 8;
  localparam int NF  = 6;
  localparam int TPO = 8;
  localparam int NV  = NI + NF;
  localparam int NC  = 2 * NV;
  localparam int FB  = NO * TPO * NC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgValid = 1'b0;
  logic cfgBit = 1'b0;
  logic cfgDone;
  logic [NI-1:0] dedIn = '0;
  logic [NF-1:0] ioIn = '0;
  logic [NO-1:0] ioOut, ioOe;

  int checks = 0;
  int fails = 0;
  logic [FB-1:0] img;

  always #2 clk = ~clk;

  pal_array dut_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgBit(cfgBit),
    .cfgDone(cfgDone), .dedIn(dedIn), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input logic [31:0] s);
    logic [31:0] x;
    x = s * 32'h9E3779B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    return x;
  endfunction

  function automatic int fIdx(input int o, input int t, input int col);
    return ((o * TPO) + t) * NC + col;
  endfunction

  // Term value straight from the requirement: connected literals ANDed.
  function automatic logic termEval(input int o, input int t, input logic [NV-1:0] vars);
    for (int v = 0; v < NV; v++) begin
      if (img[fIdx(o, t, 2*v)] && !vars[v]) return 1'b0;
      if (img[fIdx(o, t, 2*v+1)] && vars[v]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic setTerm(input int o, input int t, input logic val);
    for (int c = 0; c < NC; c++) img[fIdx(o, t, c)] = val;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cfgValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic loadImg(input bit probe);
    for (int i = 0; i < FB; i++) begin
      @(negedge clk);
      cfgValid = 1'b1;
      cfgBit = img[i];
      if (i == FB - 1) chk("R2 done before last bit", 32'(cfgDone), 32'd0);
      if (probe && (i % 256 == 100)) begin
        dedIn = mix(32'(i))[NI-1:0];
        ioIn = mix(32'(i) + 7)[NF-1:0];
        #1;
        chk("R3 pins disabled during load", 32'(ioOe), 32'd0);
      end
    end
    @(negedge clk);
    cfgValid = 1'b0;
    chk("R2 done after last bit", 32'(cfgDone), 32'd1);
  endtask

  task automatic checkVector(input string tagOut, input string tagOe,
                             input logic [NI-1:0] d, input logic [NF-1:0] e);
    logic [NV-1:0] vars;
    logic [NO-1:0] expOut, expOe;
    logic orv;
    dedIn = d;
    ioIn = e;
    #1;
    vars = {e, d};
    for (int o = 0; o < NO; o++) begin
      expOe[o] = termEval(o, 0, vars);
      orv = 1'b0;
      for (int t = 1; t < TPO; t++) orv = orv | termEval(o, t, vars);
      expOut[o] = ~orv;
    end
    chk(tagOut, 32'(ioOut), 32'(expOut));
    chk(tagOe, 32'(ioOe), 32'(expOe));
  endtask

  task automatic buildMixed();
    logic [31:0] h;
    img = '0;
    for (int o = 0; o < NO; o++)
      for (int t = 1; t < TPO; t++)
        for (int v = 0; v < NV; v++) begin
          h = mix(32'(o * 1000 + t * 100 + v));
          if (h[1:0] == 2'b00) img[fIdx(o, t, 2*v + int'(h[8]))] = 1'b1;
        end
    for (int o = 0; o < NF; o++) setTerm(o, 0, 1'b1);   // read-back pins off
    setTerm(6, 0, 1'b0);                                // pin 6 always on
    setTerm(7, 0, 1'b0);
    img[fIdx(7, 0, 0)] = 1'b1;                          // pin 7 on when dedIn[0]
    for (int t = 1; t < TPO; t++) setTerm(3, t, 1'b1);  // out 3 all terms dead
    setTerm(6, 4, 1'b0);                                // out 6 one term always true
    for (int t = 1; t < TPO; t++) setTerm(7, t, 1'b1);
    setTerm(7, 1, 1'b0);
    img[fIdx(7, 1, 2*10)] = 1'b1;                       // term = ioIn[0]
    setTerm(7, 2, 1'b0);
    img[fIdx(7, 2, 2*15 + 1)] = 1'b1;                   // term = ~ioIn[5]
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    doReset();
    // R1
    chk("R1 reset done", 32'(cfgDone), 32'd0);
    chk("R1 reset oe", 32'(ioOe), 32'd0);

    // R10: fully intact map
    img = '1;
    loadImg(1'b1);
    for (int i = 0; i < 64; i++) begin
      dedIn = mix(32'(i))[NI-1:0];
      ioIn = mix(32'(i) + 3)[NF-1:0];
      #1;
      chk("R10 intact map oe", 32'(ioOe), 32'd0);
      chk("R10 intact map out", 32'(ioOut), 32'hFF);
    end

    // Mixed map
    doReset();
    chk("R1 reset done again", 32'(cfgDone), 32'd0);
    buildMixed();
    loadImg(1'b1);
    for (int d = 0; d < 1024; d++)
      checkVector("R7 sum sweep", "R8 enable sweep", NI'(d), mix(32'(d) + 99)[NF-1:0]);
    for (int e = 0; e < 64; e++)
      checkVector("R9 read-back sweep out", "R9 read-back sweep oe", NI'(10'h2A5), NF'(e));

    // Directed: R6, R5, R9
    for (int e = 0; e < 64; e++) begin
      dedIn = NI'(e * 17);
      ioIn = NF'(e);
      #1;
      chk("R6 all-intact sum terms give 1", 32'(ioOut[3]), 32'd1);
      chk("R6 all-open term gives 0", 32'(ioOut[6]), 32'd0);
      chk("R6 all-open enable", 32'(ioOe[6]), 32'd1);
      chk("R9 pin 7 from ioIn0 and ioIn5", 32'(ioOut[7]), 32'(~(ioIn[0] | ~ioIn[5])));
      chk("R5 pin 7 enable on dedIn0", 32'(ioOe[7]), 32'(dedIn[0]));
      chk("R5 read-back pins off", 32'(ioOe[5:0]), 32'd0);
    end

    // R4: extra bits after done are ignored
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      cfgValid = 1'b1;
      cfgBit = mix(32'(i) + 555)[0];
    end
    @(negedge clk);
    cfgValid = 1'b0;
    chk("R4 done stays", 32'(cfgDone), 32'd1);
    for (int d = 0; d < 256; d++)
      checkVector("R4 map unchanged out", "R4 map unchanged oe",
                  NI'(d * 4 + 1), mix(32'(d) + 4242)[NF-1:0]);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule